// File: doc/BRIEF.md
# Fixed-Loop Seven-Segment Sequence Counter

This block is a synchronous 3-bit counter built from D-type registers. It does not count in binary. On each rising clock edge where it is enabled it steps through the loop 1, 3, 6, 0 and then returns to 1. The next value of each register comes from a minimized D-input equation, not from a lookup table.

A second registered stage turns the current value into an active-low seven-segment pattern for the matching decimal digit. This stage is updated in the same edge as the state, so the pattern and the state never differ by a cycle. The display changes only when the clock advances the counter.

The value loaded by reset is a parameter. Its default is 1. Every code outside the loop follows the same equations, so the counter always starts by itself and finds its way into the loop.

Top module: `cseq_counter`

## Requirements
- R1: While `rst` is high at a rising edge, `state` loads `RESET_CODE` (default 1) on that edge. `seg_n` shows the digit for that code from the same edge.
- R2: With `en` high and the state in the loop, each edge moves the state 1→3, 3→6, 6→0 and 0→1.
- R3: The unused codes step 2→4, 4→1, 5→3 and 7→2. From any code, the state is in the loop {0,1,3,6} after at most three enabled edges.
- R4: With `rst` low and `en` low at an edge, `state` and `seg_n` keep their values.
- R5: `seg_n` is active-low with bit 0 = a, bit 1 = b, up to bit 6 = g. It shows the decimal digit equal to `state`. The active-high patterns {g..a} are 0:3F, 1:06, 2:5B, 3:4F, 4:66, 5:6D, 6:7D, 7:07.
- R6: Reset takes priority over enable: `rst` high loads `RESET_CODE` even when `en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance enable; low holds the state |
| state | output | 3 | Current counter value |
| seg_n | output | 7 | Active-low segments, bit 0 = a through bit 6 = g |

## Verification
The unused codes cannot be reached from the ports of a counter that resets to 1, because neither reset nor enable can put it into 2, 4, 5 or 7. The bench therefore builds eight extra copies of the block, one for each possible `RESET_CODE`. Each copy starts from its own code, so one reset places a copy in every code, legal or not, at the same time. A shared enable and reset, held or driven at random, then exercise the recovery paths, holding and re-entry together with the main loop. Each copy is compared against a table-based reference model.

// File: rtl/cseq_pkg.sv
package cseq_pkg;
  localparam int STATE_W = 3;
  localparam int SEG_W   = 7;
  localparam int NCODES  = 1 << STATE_W;
  typedef logic [STATE_W-1:0] code_t;
  typedef logic [SEG_W-1:0]   seg_t;
endpackage

// File: rtl/cseq_next_logic.sv
module cseq_next_logic
  import cseq_pkg::*;
(
  input  code_t q,
  output code_t d
);
  // Minimized D-input equations
  assign d[2] = ~q[2] & q[1];
  assign d[1] = q[0];
  assign d[0] = ~q[1];
endmodule

// File: rtl/cseq_state_reg.sv
module cseq_state_reg
  import cseq_pkg::*;
#(
  parameter code_t RESET_CODE = 3'd1
)(
  input  logic  clk,
  input  logic  rst,
  input  logic  en,
  input  code_t d,
  output code_t q
);
  for (genvar i = 0; i < STATE_W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)     q[i] <= RESET_CODE[i];
      else if (en) q[i] <= d[i];
    end
  end

  p_reset_r1: assert property (@(posedge clk) rst |=> q == RESET_CODE);
  p_hold_r4: assert property (@(posedge clk) disable iff (rst) !en |=> $stable(q));
  p_loop_r2: assert property (@(posedge clk) disable iff (rst)
    (en && q == 3'd3) |=> q == 3'd6);
  p_recover_r3: assert property (@(posedge clk) disable iff (rst)
    (en && q == 3'd7) |=> q == 3'd2);
endmodule

// File: rtl/cseq_seg_decode.sv
module cseq_seg_decode
  import cseq_pkg::*;
#(
  parameter code_t RESET_CODE = 3'd1
)(
  input  logic  clk,
  input  logic  rst,
  input  logic  en,
  input  code_t nxt,
  output seg_t  seg_n
);
  function automatic seg_t pattern(input code_t c);
    case (c)
      3'd0:    pattern = 7'h3F;
      3'd1:    pattern = 7'h06;
      3'd2:    pattern = 7'h5B;
      3'd3:    pattern = 7'h4F;
      3'd4:    pattern = 7'h66;
      3'd5:    pattern = 7'h6D;
      3'd6:    pattern = 7'h7D;
      default: pattern = 7'h07;
    endcase
  endfunction

  // Registered from the next code so it lines up with the state register
  always_ff @(posedge clk) begin
    if (rst)     seg_n <= ~pattern(RESET_CODE);
    else if (en) seg_n <= ~pattern(nxt);
  end

  p_seg_hold_r4: assert property (@(posedge clk) disable iff (rst) !en |=> $stable(seg_n));
  p_seg_reset_r6: assert property (@(posedge clk) (rst && !en) |=> seg_n == ~pattern(RESET_CODE));
endmodule

// File: rtl/cseq_counter.sv
module cseq_counter
  import cseq_pkg::*;
#(
  parameter code_t RESET_CODE = 3'd1
)(
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  output logic [2:0] state,
  output logic [6:0] seg_n
);
  code_t q, d;

  cseq_next_logic u_next (.q(q), .d(d));

  cseq_state_reg #(.RESET_CODE(RESET_CODE)) u_reg (
    .clk(clk), .rst(rst), .en(en), .d(d), .q(q)
  );

  cseq_seg_decode #(.RESET_CODE(RESET_CODE)) u_seg (
    .clk(clk), .rst(rst), .en(en), .nxt(d), .seg_n(seg_n)
  );

  assign state = q;

  // The segment register and the state register must agree on digit one
  p_seg_match_r5: assert property (@(posedge clk) disable iff (rst)
    (state == 3'd1) |-> seg_n == 7'h79);
  p_loop_closed_r2: assert property (@(posedge clk) disable iff (rst)
    (en && (state == 3'd0 || state == 3'd1 || state == 3'd3 || state == 3'd6))
    |=> (state == 3'd0 || state == 3'd1 || state == 3'd3 || state == 3'd6));
endmodule

// File: tb/cseq_counter_test.sv
module cseq_counter_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  always #10 clk = ~clk;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [2:0] st_u;
  logic [6:0] sg_u;
  logic [2:0] st_k [8];
  logic [6:0] sg_k [8];
  logic [2:0] exp_k [8];

  cseq_counter uut (.clk(clk), .rst(rst), .en(en), .state(st_u), .seg_n(sg_u));

  for (genvar k = 0; k < 8; k++) begin : g_inst
    cseq_counter #(.RESET_CODE(k)) u_k (
      .clk(clk), .rst(rst), .en(en), .state(st_k[k]), .seg_n(sg_k[k])
    );
  end

  function automatic logic [2:0] ref_next(input logic [2:0] c);
    case (c)
      3'd1: return 3'd3;
      3'd3: return 3'd6;
      3'd6: return 3'd0;
      3'd0: return 3'd1;
      3'd2: return 3'd4;
      3'd4: return 3'd1;
      3'd5: return 3'd3;
      default: return 3'd2;
    endcase
  endfunction

  function automatic logic [6:0] ref_seg(input logic [2:0] c);
    logic [6:0] p;
    case (c)
      3'd0: p = 7'h3F; 3'd1: p = 7'h06; 3'd2: p = 7'h5B; 3'd3: p = 7'h4F;
      3'd4: p = 7'h66; 3'd5: p = 7'h6D; 3'd6: p = 7'h7D; default: p = 7'h07;
    endcase
    return ~p;
  endfunction

  function automatic bit in_loop(input logic [2:0] c);
    return c == 3'd0 || c == 3'd1 || c == 3'd3 || c == 3'd6;
  endfunction

  task automatic check(input string req, input logic [6:0] act, input logic [6:0] expv);
    vectors++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // One edge: update model from the inputs applied before it, then compare
  task automatic tick(input string req);
    @(posedge clk);
    #5;
    for (int k = 0; k < 8; k++) begin
      if (rst)     exp_k[k] = 3'(k);
      else if (en) exp_k[k] = ref_next(exp_k[k]);
      check({req, " state"}, {4'd0, st_k[k]}, {4'd0, exp_k[k]});
      check("R5 seg", sg_k[k], ref_seg(exp_k[k]));
    end
    check({req, " uut"}, {4'd0, st_u}, {4'd0, exp_k[1]});
    check("R5 uut seg", sg_u, ref_seg(exp_k[1]));
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1729));
    for (int k = 0; k < 8; k++) exp_k[k] = 3'(k);
    rst = 1'b1; en = 1'b0;
    tick("R1 reset");
    rst = 1'b0; en = 1'b1;
    // R2 / R3: first full rotation from every starting code
    for (int i = 0; i < 8; i++) begin
      tick(i < 3 ? "R3 recover" : "R2 loop");
      if (i == 2)
        for (int k = 0; k < 8; k++)
          check("R3 in loop", {6'd0, in_loop(st_k[k])}, 7'd1);
    end
    // R4: hold with enable low
    en = 1'b0;
    for (int i = 0; i < 4; i++) tick("R4 hold");
    // R6: reset while disabled
    rst = 1'b1;
    tick("R6 reset priority");
    rst = 1'b0;
    tick("R4 hold after reset");
    en = 1'b1;
    tick("R2 step");
    // Random mix of enable and reset
    for (int i = 0; i < 400; i++) begin
      en  = 1'(($urandom % 4) != 0);
      rst = 1'(($urandom % 16) == 0);
      tick(rst ? "R1 random reset" : (en ? "R2 random step" : "R4 random hold"));
    end
    rst = 1'b0; en = 1'b0;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule